// File: doc/BRIEF.md
# Serial Management Bus Register Slave

This block is the target side of a two-wire serial management bus, sitting in front of a small bank of byte-wide registers. The system clock runs much faster than the bus clock. Both bus lines are synchronised and edge-detected on that clock. The block detects START and STOP conditions and takes in an address byte. It acknowledges only when the address byte names this device, or when it names the alert-response address while the local alert input is raised.

The device address has a fixed five-bit prefix and a two-bit suffix. The suffix comes from a three-way strap input that is captured while reset is held. In a write, the first byte after the address sets a register pointer, and each later byte is stored at that pointer. In a read, the register at the pointer is returned for every byte the host asks for. The pointer never advances on its own. A host therefore sets the pointer with a short write and then reads, either after a repeated START or after a STOP.

The data line is modelled as an open-drain output: the block only ever pulls it low. It changes its pull-down only while the bus clock is low.

Top module: `smb_reg_slave`

## Requirements
- R1: The device address is the 7-bit value {01011, S1, S0}. The two-bit strap code selects S1S0: code 0 (grounded) gives 00, code 1 (tied high) gives 01, and codes 2 and 3 (open) give 10. A matching address byte is acknowledged by pulling the data line low during the ninth bus clock.
- R2: The strap code is captured only while reset is asserted. Changing it after reset has no effect on which address is acknowledged.
- R3: An address byte that matches neither address is not acknowledged. The data line stays released, and any bytes that follow are neither acknowledged nor stored until the next START.
- R4: In a write, the first byte after the address loads the register pointer. Every later byte in the same transfer is acknowledged and stored at the pointed register, and the pointer does not advance.
- R5: In a read (R/W bit = 1), every byte sent holds the register at the pointer, MSB first. After a byte that the host does not acknowledge, the block releases the data line and waits for a new START.
- R6: With the alert input high, a read addressed to 0001100 is acknowledged and returns {device address, 0}. With the alert input low, that address is not acknowledged.
- R7: A STOP (data rising while the clock is high) returns the block to idle and leaves the pointer unchanged. A later read returns the register at that pointer.
- R8: The data-line pull-down changes only while the synchronised bus clock is low.
- R9: A repeated START in the middle of a transfer restarts the address phase.
- R10: Reset releases the data line and clears all registers to 0x00.
- R11: A pointer value at or above the register count (default 8) makes writes have no effect and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_i | input | 2 | Address strap code: 0 grounded, 1 tied high, 2/3 open |
| alert_i | input | 1 | Local alert request; enables the alert-response reply |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The alert-response match and the own-address match are decided in the same cycle, on the same completed address byte. The bench raises the alert input and addresses the device both by its own address and by the alert-response address. It expects each case to be acknowledged, and the returned byte to be the register contents in one case and the shifted device address in the other. A second pairing is the last pointer-write acknowledge followed at once by a STOP. The pointer loaded in the final byte must survive the STOP, and this is judged by a later read returning that register's value.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK
  } smb_state_e;

  localparam logic [4:0] DEV_PREFIX   = 5'b01011;
  localparam logic [6:0] ALERT_REPLY  = 7'b0001100;

  // strap code to the two low address bits
  function automatic logic [1:0] strap_low_bits(input logic [1:0] code);
    case (code)
      2'd0:    strap_low_bits = 2'b00;
      2'd1:    strap_low_bits = 2'b01;
      default: strap_low_bits = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_lvl   = scl_s;
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [7:0]    waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [7:0]    raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [7:0] LIMIT = 8'(NREGS);

  logic [NREGS-1:0][DW-1:0] mem;
  logic                     wr_ok;

  assign wr_ok = we_i && (waddr_i < LIMIT);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic en;
    assign en = wr_ok && (waddr_i[IW-1:0] == IW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[r] <= '0;
      else if (en) mem[r] <= wdata_i;
    end
  end

  always_comb begin
    if (raddr_i < LIMIT) rdata_o = mem[raddr_i[IW-1:0]];
    else                 rdata_o = '0;
  end

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int NREGS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  input  logic       alert_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o
);

  localparam int DW = 8;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [1:0] sync_q;
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (sync_q)
  );

  smb_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (sync_q[1]),
    .sda_s     (sync_q[0]),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // strap capture: loads only while reset is held
  logic [1:0] strap_q;
  logic [6:0] own_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  assign own_addr = {DEV_PREFIX, strap_low_bits(strap_q)};

  // state registers and their next values
  smb_state_e    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] shreg, shreg_n;
  logic [7:0]    ptr, ptr_n;
  logic          done, done_n;
  logic          rw, rw_n;
  logic          ara, ara_n;
  logic          first, first_n;
  logic          nack, nack_n;
  logic          pull, pull_n;
  logic          reg_we;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] tx_byte;
  logic          own_hit, ara_hit;

  smb_regfile #(.NREGS(NREGS), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .waddr_i (ptr),
    .wdata_i (shreg),
    .raddr_i (ptr),
    .rdata_o (reg_rdata)
  );

  assign own_hit = (shreg[7:1] == own_addr);
  assign ara_hit = (shreg[7:1] == ALERT_REPLY) && shreg[0] && alert_i;
  assign tx_byte = ara ? {own_addr, 1'b0} : reg_rdata;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    shreg_n = shreg;
    ptr_n   = ptr;
    done_n  = done;
    rw_n    = rw;
    ara_n   = ara;
    first_n = first;
    nack_n  = nack;
    pull_n  = pull;
    reg_we  = 1'b0;

    if (stop_det) begin
      state_n = S_IDLE;
      pull_n  = 1'b0;
    end else if (start_det) begin
      state_n = S_ADDR;
      cnt_n   = '0;
      done_n  = 1'b0;
      pull_n  = 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WDATA: begin
          if (scl_rise && !done) begin
            shreg_n = {shreg[DW-2:0], sda_lvl};
            cnt_n   = cnt + 1'b1;
            if (cnt == LAST_BIT) done_n = 1'b1;
          end
          if (scl_fall && done) begin
            done_n = 1'b0;
            cnt_n  = '0;
            if (state == S_ADDR) begin
              if (own_hit || ara_hit) begin
                state_n = S_AACK;
                pull_n  = 1'b1;
                rw_n    = shreg[0];
                ara_n   = ara_hit;
              end else begin
                state_n = S_IDLE;
              end
            end else begin
              if (first) begin
                ptr_n   = shreg;
                first_n = 1'b0;
              end else begin
                reg_we = 1'b1;
              end
              state_n = S_WACK;
              pull_n  = 1'b1;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              state_n = S_RDATA;
              shreg_n = tx_byte;
              pull_n  = ~tx_byte[DW-1];
            end else begin
              state_n = S_WDATA;
              first_n = 1'b1;
              pull_n  = 1'b0;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            state_n = S_WDATA;
            pull_n  = 1'b0;
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              state_n = S_RACK;
              pull_n  = 1'b0;
            end else begin
              shreg_n = {shreg[DW-2:0], 1'b0};
              pull_n  = ~shreg[DW-2];
              cnt_n   = cnt + 1'b1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) nack_n = sda_lvl;
          if (scl_fall) begin
            if (nack) begin
              state_n = S_IDLE;
            end else begin
              state_n = S_RDATA;
              cnt_n   = '0;
              shreg_n = tx_byte;
              pull_n  = ~tx_byte[DW-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      shreg <= '0;
      ptr   <= '0;
      done  <= 1'b0;
      rw    <= 1'b0;
      ara   <= 1'b0;
      first <= 1'b0;
      nack  <= 1'b0;
      pull  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      shreg <= shreg_n;
      ptr   <= ptr_n;
      done  <= done_n;
      rw    <= rw_n;
      ara   <= ara_n;
      first <= first_n;
      nack  <= nack_n;
      pull  <= pull_n;
    end
  end

  assign sda_pull_o = pull;

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_pull_o,
  input smb_state_e state,
  input logic       stop_det,
  input logic [7:0] ptr,
  input logic [7:0] shreg,
  input logic [6:0] own_addr
);

  // R8: pull-down moves only with the bus clock low
  a_r8_pull_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl);

  // R3: idle never drives the line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull_o);

  // R1: address acknowledge only for a matching address byte
  a_r1_ack_matches: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) && state == S_AACK) |->
      ((shreg[7:1] == own_addr) || (shreg[7:1] == ALERT_REPLY)));

  // R7: STOP leaves the pointer alone
  a_r7_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> $stable(ptr));

  // R2: strap-derived address fixed outside reset
  a_r2_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(own_addr));

  // R5: line released while host answers a read byte
  a_r5_rack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK) |-> !sda_pull_o);

  // R10: released under reset
  a_r10_reset_released: assert property (@(posedge clk)
    !rst_n |-> !sda_pull_o);

endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .sda_pull_o (sda_pull_o),
  .state      (state),
  .stop_det   (stop_det),
  .ptr        (ptr),
  .shreg      (shreg),
  .own_addr   (own_addr)
);

// File: tb/test_smb_reg_slave.sv
`timescale 1ns/1ps
module test_smb_reg_slave;

  localparam int Q = 10;
  localparam logic [6:0] ARA = 7'b0001100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] strap;
  logic       alert;
  logic       scl;
  logic       msda;
  logic       sda_pull;
  logic       sda_line;
  int         vecs = 0;
  int         fails = 0;
  logic       finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = msda & ~sda_pull;

  smb_reg_slave i_smb_reg_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_i    (strap),
    .alert_i    (alert),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic [1:0] code);
    logic [1:0] lo;
    lo = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b10;
    return 7'h2C | {5'b0, lo};
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic do_reset(input logic [1:0] code);
    strap = code;
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic bus_start();
    tick(Q/2); msda = 1'b1;
    tick(Q/2); scl = 1'b1;
    tick(Q);   msda = 1'b0;
    tick(Q);   scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q/2); msda = 1'b0;
    tick(Q/2); scl = 1'b1;
    tick(Q);   msda = 1'b1;
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q/2); msda = b[i];
      tick(Q/2); scl = 1'b1;
      tick(Q);   scl = 1'b0;
    end
    tick(Q/2); msda = 1'b1;
    tick(Q/2); scl = 1'b1;
    tick(Q/2); ack = ~sda_line;
    tick(Q/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(Q/2); msda = 1'b1;
      tick(Q/2); scl = 1'b1;
      tick(Q/2); d[i] = sda_line;
      tick(Q/2); scl = 1'b0;
    end
    tick(Q/2); msda = ~mack;
    tick(Q/2); scl = 1'b1;
    tick(Q);   scl = 1'b0;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                        output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  // pointer write, repeated START, single read
  task automatic rd_reg(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
    logic ak;
    bus_start();
    send_byte({a, 1'b0}, ak);
    send_byte(p, ak);
    bus_start();
    send_byte({a, 1'b1}, ak);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    logic       a0, a1, a2;
    logic [7:0] d, d1, d2;
    logic [6:0] own;
    rst_n = 1'b0; strap = 2'd2; alert = 1'b0; scl = 1'b1; msda = 1'b1;
    tick(2);
    do_reset(2'd2);
    own = exp_addr(2'd2);

    // R10: reset state
    chk("R10 line released", int'(sda_pull), 0);
    rd_reg(own, 8'd5, d);
    chk("R10 register cleared", int'(d), 0);

    // R1 / R3: full address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, a0);
      bus_stop();
      chk((7'(a) == own) ? "R1 own ack" : "R3 foreign no ack", int'(a0), int'(7'(a) == own));
    end

    // R1: other strap codes
    for (int c = 0; c < 4; c++) begin
      do_reset(2'(c));
      for (int k = 0; k < 4; k++) begin
        bus_start();
        send_byte({7'(7'h2C + k), 1'b0}, a0);
        bus_stop();
        chk("R1 strap decode", int'(a0), int'(7'(7'h2C + k) == exp_addr(2'(c))));
      end
    end

    // R2: strap change after reset ignored
    do_reset(2'd2);
    strap = 2'd0;
    tick(4);
    bus_start(); send_byte({7'h2E, 1'b0}, a0); bus_stop();
    chk("R2 latched address still acked", int'(a0), 1);
    bus_start(); send_byte({7'h2C, 1'b0}, a0); bus_stop();
    chk("R2 new strap address ignored", int'(a0), 0);
    own = 7'h2E;

    // R4: two data bytes to one pointer
    bus_start();
    send_byte({own, 1'b0}, a0);
    send_byte(8'd3, a1);
    send_byte(8'hA5, a2);
    chk("R4 data ack", int'(a2), 1);
    send_byte(8'h5A, a2);
    bus_stop();
    rd_reg(own, 8'd3, d);
    chk("R4 last byte at pointer", int'(d), 8'h5A);
    rd_reg(own, 8'd4, d);
    chk("R4 no auto increment", int'(d), 0);

    // R4 / R5: fill and read back every register
    for (int i = 0; i < 8; i++) wr_reg(own, 8'(i), pat(i), a0, a1, a2);
    for (int i = 0; i < 8; i++) begin
      rd_reg(own, 8'(i), d);
      chk("R5 read back", int'(d), int'(pat(i)));
    end

    // R5 / R9: repeated START, multi-byte read, NACK release
    bus_start();
    send_byte({own, 1'b0}, a0);
    send_byte(8'd6, a1);
    bus_start();
    send_byte({own, 1'b1}, a0);
    chk("R9 restart read ack", int'(a0), 1);
    recv_byte(1'b1, d);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    chk("R5 byte 0", int'(d), int'(pat(6)));
    chk("R5 byte 1 same reg", int'(d1), int'(pat(6)));
    chk("R5 byte 2 same reg", int'(d2), int'(pat(6)));
    tick(6);
    chk("R5 released after nack", int'(sda_pull), 0);
    bus_stop();

    // R3: foreign write bytes not stored
    wr_reg(7'h30, 8'd2, 8'hFF, a0, a1, a2);
    chk("R3 foreign data no ack", int'(a1 | a2), 0);
    rd_reg(own, 8'd2, d);
    chk("R3 register untouched", int'(d), int'(pat(2)));

    // R6: alert response, and own read in the same alert window
    alert = 1'b1;
    bus_start(); send_byte({ARA, 1'b1}, a0);
    chk("R6 alert reply ack", int'(a0), 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R6 alert reply byte", int'(d), int'({own, 1'b0}));
    rd_reg(own, 8'd1, d);
    chk("R6 own read with alert high", int'(d), int'(pat(1)));
    alert = 1'b0;
    bus_start(); send_byte({ARA, 1'b1}, a0); bus_stop();
    chk("R6 no reply without alert", int'(a0), 0);

    // R7: pointer survives STOP
    bus_start(); send_byte({own, 1'b0}, a0); send_byte(8'd4, a1); bus_stop();
    bus_start(); send_byte({own, 1'b1}, a0); recv_byte(1'b0, d); bus_stop();
    chk("R7 pointer kept over stop", int'(d), int'(pat(4)));

    // R11: out-of-range pointer
    wr_reg(own, 8'h20, 8'h77, a0, a1, a2);
    rd_reg(own, 8'h20, d);
    chk("R11 out of range reads zero", int'(d), 0);
    rd_reg(own, 8'd0, d);
    chk("R11 reg 0 untouched", int'(d), int'(pat(0)));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      vecs++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule